// File: doc/BRIEF.md
# Fixed-Point PI Regulator with Integrator Freeze

This block is a proportional-integral regulator for the inner loops of a motor drive. It can serve the current loops or the speed loop. A single-cycle sample strobe starts each update. At that moment the block captures a signed set-point, a signed measurement, two signed fixed-point gains and a symmetric output bound. Three clock edges later it presents a bounded control output, a flag that says whether the bound was hit, and a one-cycle valid pulse.

The integral gain input already includes the sample period. For a loop sampled every 10 µs, software loads Ki·Ts into it. The integrator holds its value while the output is bounded, so the integrator does not wind up. The integrator also has its own bound at the same magnitude as the output.

The update runs under a three-state sequencer:
- `ST_IDLE` waits for the strobe. Transition `T_START` (strobe seen) captures the inputs, forms the error and moves to `ST_MUL`.
- `ST_MUL` registers both rounded gain products. Transition `T_PROD` then moves to `ST_ACC`.
- `ST_ACC` sums the terms, bounds the result and updates the integrator and the outputs. Transition `T_DONE` returns to `ST_IDLE`.

Top module: `pi_anti_windup`

## Requirements
- R1: On each update the error is `ref_in − fb_in`, and the unbounded sum is `integral(k−1) + P + I`. Each gain is a signed value with GF = 8 fractional bits, so 256 stands for 1.0. Each term is `floor((K·e + 128) / 256)`, which rounds halves toward plus infinity (for example, −2.5 rounds to −2).
- R2: When the update does not saturate, the integrator becomes `integral + I`.
- R3: When the update saturates, the integrator keeps its previous value.
- R4: `u_out` is the unbounded sum clamped to the range [−lim_in, +lim_in].
- R5: `sat_out` is 1 exactly when the unbounded sum is strictly greater than +lim_in or strictly less than −lim_in. A sum equal to ±lim_in gives 0. The flag updates together with `u_out`.
- R6: `vld_out` is high for exactly one cycle, at the third rising edge counted from the edge that samples the strobe. `u_out` and `sat_out` hold their values between updates.
- R7: A strobe that arrives while an update is in progress is ignored: it produces no extra valid pulse, and its inputs are not captured.
- R8: A synchronous active-high `rst` clears the integrator, `u_out`, `sat_out` and `vld_out` to zero.
- R9: In a non-saturating update where `integral + I` lies outside ±lim_in, the integrator is clamped to ±lim_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | Sample strobe that starts an update |
| ref_in | input | DW | Signed set-point |
| fb_in | input | DW | Signed measurement |
| kp_in | input | GW | Signed proportional gain, GF fractional bits |
| ki_in | input | GW | Signed integral gain times sample period, GF fractional bits |
| lim_in | input | DW-1 | Unsigned magnitude of the symmetric bound |
| u_out | output | DW | Signed bounded control output |
| sat_out | output | 1 | Bound was hit on the last update |
| vld_out | output | 1 | One-cycle pulse when a new output is ready |

## Verification
The bench checks sums that land exactly on +lim and on −lim, and sums one step beyond each. A design that compares with ≥ instead of > would raise the flag one step too early. The bench also checks a negative half-way product, so truncation or round-away-from-zero would be off by one. After saturated samples, an ordinary sample makes the held integrator visible at the output; a design that accumulated during saturation would show a larger output. A gain pair with opposite signs drives the integrator past the bound without saturating the output, so a missing integrator clamp shows up in the next output. A strobe repeated while the update is in progress must yield one valid pulse carrying the first inputs.

// File: rtl/pi_pkg.sv
package pi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_ACC  = 2'd2
    } pi_state_e;
endpackage

// File: rtl/pi_scale.sv
// Signed gain multiply, rounded half-up and shifted back by GF bits.
module pi_scale #(
    parameter int EW = 17,
    parameter int GW = 16,
    parameter int GF = 8
) (
    input  logic signed [EW-1:0]    err,
    input  logic signed [GW-1:0]    gain,
    output logic signed [EW+GW-1:0] term
);
    localparam int PW = EW + GW;
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (GF - 1);

    logic signed [PW-1:0] prod;

    always_comb begin
        prod = err * gain;
        term = (prod + HALF) >>> GF;
    end
endmodule

// File: rtl/pi_clamp.sv
// Symmetric bound of a wide signed value to +/-lim, with an out-of-range flag.
module pi_clamp #(
    parameter int IW = 35,
    parameter int DW = 16
) (
    input  logic signed [IW-1:0] val,
    input  logic        [DW-2:0] lim,
    output logic signed [DW-1:0] y,
    output logic                 clip
);
    logic signed [IW-1:0] lim_w;
    logic signed [DW-1:0] lim_n;
    logic                 over_hi;
    logic                 over_lo;

    always_comb begin
        lim_w   = $signed({{(IW-DW+1){1'b0}}, lim});
        lim_n   = $signed({1'b0, lim});
        over_hi = val > lim_w;
        over_lo = val < -lim_w;
        clip    = over_hi | over_lo;
        if (over_hi)      y = lim_n;
        else if (over_lo) y = -lim_n;
        else              y = val[DW-1:0];
    end
endmodule

// File: rtl/pi_anti_windup.sv
module pi_anti_windup
    import pi_pkg::*;
#(
    parameter int DW = 16,
    parameter int GW = 16,
    parameter int GF = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_stb,
    input  logic signed [DW-1:0] ref_in,
    input  logic signed [DW-1:0] fb_in,
    input  logic signed [GW-1:0] kp_in,
    input  logic signed [GW-1:0] ki_in,
    input  logic        [DW-2:0] lim_in,
    output logic signed [DW-1:0] u_out,
    output logic                 sat_out,
    output logic                 vld_out
);
    localparam int EW = DW + 1;   // error width
    localparam int PW = EW + GW;  // product width
    localparam int SW = PW + 2;   // sum width

    pi_state_e state_q, state_d;

    logic signed [EW-1:0] err_q;
    logic signed [EW-1:0] err_d;
    logic signed [GW-1:0] kp_q, ki_q;
    logic        [DW-2:0] lim_q;
    logic signed [PW-1:0] p_term, i_term;
    logic signed [PW-1:0] p_q, i_q;
    logic signed [DW-1:0] integ_q;
    logic signed [SW-1:0] integ_w;
    logic signed [SW-1:0] sum_w;
    logic signed [SW-1:0] isum_w;
    logic signed [DW-1:0] u_c, integ_c;
    logic                 sum_clip, integ_clip;

    // ---------------- datapath pieces ----------------
    assign err_d = $signed({ref_in[DW-1], ref_in}) - $signed({fb_in[DW-1], fb_in});

    pi_scale #(.EW(EW), .GW(GW), .GF(GF)) u_pscale (
        .err(err_q), .gain(kp_q), .term(p_term)
    );
    pi_scale #(.EW(EW), .GW(GW), .GF(GF)) u_iscale (
        .err(err_q), .gain(ki_q), .term(i_term)
    );

    always_comb begin
        integ_w = {{(SW-DW){integ_q[DW-1]}}, integ_q};
        sum_w   = integ_w + {{2{p_q[PW-1]}}, p_q} + {{2{i_q[PW-1]}}, i_q};
        isum_w  = integ_w + {{2{i_q[PW-1]}}, i_q};
    end

    pi_clamp #(.IW(SW), .DW(DW)) u_out_clamp (
        .val(sum_w), .lim(lim_q), .y(u_c), .clip(sum_clip)
    );
    pi_clamp #(.IW(SW), .DW(DW)) u_int_clamp (
        .val(isum_w), .lim(lim_q), .y(integ_c), .clip(integ_clip)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (smp_stb) state_d = ST_MUL;   // T_START
            ST_MUL:  state_d = ST_ACC;                // T_PROD
            ST_ACC:  state_d = ST_IDLE;               // T_DONE
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs and data registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q   <= '0;
            kp_q    <= '0;
            ki_q    <= '0;
            lim_q   <= '0;
            p_q     <= '0;
            i_q     <= '0;
            integ_q <= '0;
            u_out   <= '0;
            sat_out <= 1'b0;
            vld_out <= 1'b0;
        end else begin
            vld_out <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (smp_stb) begin
                        err_q <= err_d;
                        kp_q  <= kp_in;
                        ki_q  <= ki_in;
                        lim_q <= lim_in;
                    end
                end
                ST_MUL: begin
                    p_q <= p_term;
                    i_q <= i_term;
                end
                ST_ACC: begin
                    u_out   <= u_c;
                    sat_out <= sum_clip;
                    vld_out <= 1'b1;
                    if (!sum_clip) integ_q <= integ_c;
                end
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    // R6: valid is a single-cycle pulse
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        vld_out |=> !vld_out);

    // R3: a saturated update leaves the integrator untouched
    p_freeze_integ_r3: assert property (@(posedge clk) disable iff (rst)
        (vld_out && sat_out) |-> integ_q == $past(integ_q));

    // R4: published output lies inside the captured bound
    p_out_bounded_r4: assert property (@(posedge clk) disable iff (rst)
        vld_out |-> ($signed(u_out) <= $signed({1'b0, lim_q}) &&
                     $signed(u_out) >= -$signed({1'b0, lim_q})));

    // R5: a raised flag means the output sits on one of the bounds
    p_sat_on_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (vld_out && sat_out) |-> (u_out == $signed({1'b0, lim_q}) ||
                                  u_out == -$signed({1'b0, lim_q})));

    // R9: integrator overflow on a free update lands on a bound
    p_integ_clamp_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACC && !sum_clip && integ_clip) |=>
        (integ_q == $signed({1'b0, lim_q}) || integ_q == -$signed({1'b0, lim_q})));

    // R7: the sequencer only leaves idle through the multiply state
    p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> (state_q != ST_MUL || $past(state_q) == ST_IDLE));

    // R8: reset clears the published outputs
    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (u_out == '0 && !sat_out && !vld_out && integ_q == '0));
endmodule

// File: tb/tb_pi_anti_windup.sv
module tb_pi_anti_windup;
    localparam int DW = 16;
    localparam int GW = 16;
    localparam int GF = 8;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 smp_stb;
    logic signed [DW-1:0] ref_in, fb_in;
    logic signed [GW-1:0] kp_in, ki_in;
    logic        [DW-2:0] lim_in;
    logic signed [DW-1:0] u_out;
    logic                 sat_out, vld_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pi_anti_windup #(.DW(DW), .GW(GW), .GF(GF)) dut (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .ref_in(ref_in), .fb_in(fb_in),
        .kp_in(kp_in), .ki_in(ki_in), .lim_in(lim_in),
        .u_out(u_out), .sat_out(sat_out), .vld_out(vld_out)
    );

    // Vector table: kp = 1.0, ki = 0.25, lim = 100, walked from a cleared integrator
    localparam int NV = 6;
    localparam int T_REF [NV] = '{40, 10, 200, -100, 60, 0};
    localparam int T_FB  [NV] = '{0, 20, 0, 50, 0, 0};
    localparam int T_U   [NV] = '{50, -2, 100, -100, 83, 23};
    localparam int T_SAT [NV] = '{0, 0, 1, 1, 0, 0};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Issue one sample, return cycles to valid; checks the one-cycle pulse
    task automatic sample(input int r, input int f, output int lat);
        @(negedge clk);
        ref_in  = DW'(r);
        fb_in   = DW'(f);
        smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        lat = 1;
        while (!vld_out && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_chk(input string req, input int r, input int f,
                           input int eu, input int es);
        int lat;
        sample(r, f, lat);
        chk({req, " u_out"}, int'($signed(u_out)), eu);
        chk({req, " sat_out"}, int'(sat_out), es);
        @(negedge clk);
        chk("R6 valid drop", int'(vld_out), 0);
        chk("R6 output held", int'($signed(u_out)), eu);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        int nvld;
        int seen_u;
        rst = 1'b1; smp_stb = 1'b0; ref_in = '0; fb_in = '0;
        kp_in = 16'sd256; ki_in = 16'sd64; lim_in = 15'd100;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        chk("R8 reset u_out", int'($signed(u_out)), 0);
        chk("R8 reset sat_out", int'(sat_out), 0);
        chk("R8 reset vld_out", int'(vld_out), 0);

        // R6: latency on first sample
        sample(T_REF[0], T_FB[0], lat);
        chk("R6 latency", lat, 3);
        chk("R1 first u_out", int'($signed(u_out)), T_U[0]);
        @(negedge clk);
        chk("R6 valid drop", int'(vld_out), 0);

        // Table walk (R1 rounding, R2 accumulation, R3 freeze, R4/R5 clamp)
        for (int i = 1; i < NV; i++) begin
            run_chk("R1/R2/R3/R4/R5 vector", T_REF[i], T_FB[i], T_U[i], T_SAT[i]);
        end

        // R5 boundaries: ki = 0 so integrator stays 23
        ki_in = 16'sd0;
        run_chk("R5 sum at +lim", 77, 0, 100, 0);
        run_chk("R5 sum past +lim", 78, 0, 100, 1);
        run_chk("R5 sum at -lim", -123, 0, -100, 0);
        run_chk("R5 sum past -lim", -124, 0, -100, 1);
        run_chk("R3 integ unchanged", 0, 0, 23, 0);

        // R9: opposite-sign gains push integrator to 113 without saturating output
        kp_in = -16'sd256; ki_in = 16'sd256;
        run_chk("R9 free update", 90, 0, 23, 0);
        kp_in = 16'sd256; ki_in = 16'sd0;
        run_chk("R9 integ clamped", 0, 0, 100, 0);

        // R8: mid-run reset clears integrator
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R8 reset u_out", int'($signed(u_out)), 0);
        chk("R8 reset sat_out", int'(sat_out), 0);
        run_chk("R8 integ cleared", 0, 0, 0, 0);

        // R7: second strobe while busy is ignored
        @(negedge clk);
        ref_in = 16'sd50; fb_in = '0; smp_stb = 1'b1;
        @(negedge clk);
        ref_in = -16'sd30;
        @(negedge clk);
        smp_stb = 1'b0;
        nvld = 0; seen_u = -999;
        for (int c = 0; c < 10; c++) begin
            if (vld_out) begin
                nvld++;
                seen_u = int'($signed(u_out));
            end
            @(negedge clk);
        end
        chk("R7 single valid", nvld, 1);
        chk("R7 first inputs kept", seen_u, 50);

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule